// File: doc/BRIEF.md
# Seven-to-one flat-panel link serializer

This block feeds a flat-panel display link. A pixel-rate word is split into 7-bit groups, and each group is shifted out on one data lane across seven consecutive cycles of a bit clock that runs at seven times the pixel rate. A clock lane is produced inside the same seven-step sequence, so the panel receives a forwarded pixel clock that is phase-locked to the data. A lane-count mode selects 3, 4 or 5 active data lanes. These carry 21, 28 or 35 bits per pixel period. Panels commonly use 18, 24 or 30 of those bits for colour and the remaining bits for sync and enable. The outputs are single-ended and registered. They are meant for external differential pad drivers. The PLL that makes the bit clock is outside this block.

Upstream logic may strobe a new word and mode at any bit-clock cycle of a pixel period. The block keeps the most recent strobed word in a pending register. At the period boundary it moves that word, together with the current mode, into the word being serialized. A period therefore never mixes two words, and it never mixes two modes.

Top module: `lvds_tx_7to1`

## Requirements
- R1: A synchronous reset drives every data lane and the clock lane low and clears the pending word. The first clock edge with reset low starts step 0 of a period that serializes an all-zero word.
- R2: A period is exactly 7 bit-clock cycles, numbered steps 0 to 6, and periods repeat without gaps.
- R3: The clock lane is high on steps 0 to 3 and low on steps 4 to 6, so it rises at the start of each period.
- R4: Data lane i carries bits pix_data[7i+6:7i]. Bit 7i+6 is driven on step 0 and bit 7i on step 6, one bit per step in descending order.
- R5: lane_mode encoding: 0 enables lanes 0 to 2, 1 enables lanes 0 to 3, and 2 or 3 enables all five lanes.
- R6: A lane that is not enabled by the mode of the current period stays low for all seven steps.
- R7: A pix_load pulse on any cycle of a period, the last cycle included, makes its pix_data the word of the next period. If there are several pulses, the last one wins. With no pulse, the previous word is repeated.
- R8: lane_mode is sampled only on the boundary edge, which is the last cycle of a period. Values held on other cycles have no effect on any period.
- R9: Changes on pix_data while pix_load is low do not alter the lane outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_data | input | 35 | Parallel pixel word, 7 bits per lane, lane 0 in the low bits |
| pix_load | input | 1 | Strobe that captures pix_data into the pending register |
| lane_mode | input | 2 | Active lane count select (0: 3 lanes, 1: 4 lanes, 2/3: 5 lanes) |
| lane_out | output | 5 | Serial data bit for each lane, to the differential drivers |
| clk_lane_out | output | 1 | Forwarded clock lane bit, 4 high and 3 low per period |

## Verification
A fault in the step counter shows on the clock lane within one period, because the high and low run lengths or the rising position move away from the 4/3 shape. A wrong pending or active word becomes visible on the data lanes at the next period boundary, and bit-order faults show on the first step that differs. A mode captured on the wrong cycle shows as a lane that is lit or dark for a whole period. Stimulus therefore places strobes and mode changes at the first, middle and last cycles of a period. It also lets a word repeat with no strobe.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

  // Width of the lane-count select for a given span of lane counts.
  function automatic int mode_bits(input int lanes, input int min_lanes);
    int span;
    span = lanes - min_lanes + 1;
    return (span > 1) ? $clog2(span) : 1;
  endfunction

  // A lane is enabled when its index is below the selected lane count.
  function automatic logic lane_on(input int mode, input int idx, input int min_lanes);
    return (mode + min_lanes) > idx;
  endfunction

endpackage

// File: rtl/lvds_step_seq.sv
module lvds_step_seq #(
  parameter int STEPS = 7,
  localparam int SW = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] step_nxt_o,
  output logic          wrap_o
);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  logic [SW-1:0] step_q;

  assign wrap_o     = (step_q == LAST);
  assign step_nxt_o = wrap_o ? '0 : step_q + 1'b1;

  // Held at the last step during reset so the first live edge opens step 0.
  always_ff @(posedge clk) begin
    if (rst) step_q <= LAST;
    else     step_q <= step_nxt_o;
  end
endmodule

// File: rtl/lvds_pixel_hold.sv
module lvds_pixel_hold #(
  parameter int WW = 35,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [WW-1:0] data_i,
  input  logic [MW-1:0] mode_i,
  input  logic          capture_i,
  output logic [WW-1:0] word_nxt_o,
  output logic [MW-1:0] mode_nxt_o
);
  logic [WW-1:0] pend_q, pend_nxt, word_q;
  logic [MW-1:0] mode_q;

  // A strobe on the boundary edge itself still reaches the new period.
  assign pend_nxt   = load_i ? data_i : pend_q;
  assign word_nxt_o = capture_i ? pend_nxt : word_q;
  assign mode_nxt_o = capture_i ? mode_i : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      word_q <= '0;
      mode_q <= '0;
    end else begin
      pend_q <= pend_nxt;
      word_q <= word_nxt_o;
      mode_q <= mode_nxt_o;
    end
  end
endmodule

// File: rtl/lvds_lane_mux.sv
module lvds_lane_mux
  import lvds_ser_pkg::*;
#(
  parameter int LANES     = 5,
  parameter int MIN_LANES = 3,
  parameter int STEPS     = 7,
  localparam int SW = $clog2(STEPS),
  localparam int MW = mode_bits(LANES, MIN_LANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES*STEPS-1:0] word_i,
  input  logic [MW-1:0]          mode_i,
  input  logic [SW-1:0]          step_i,
  output logic [LANES-1:0]       lane_o
);
  logic [LANES-1:0] lane_nxt, lane_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STEPS-1:0] slice, shifted;
    assign slice       = word_i[g*STEPS +: STEPS];
    // Shifting left by the step puts the bit for that step at the top.
    assign shifted     = slice << step_i;
    assign lane_nxt[g] = lane_on(int'(mode_i), g, MIN_LANES) & shifted[STEPS-1];
  end

  always_ff @(posedge clk) begin
    if (rst) lane_q <= '0;
    else     lane_q <= lane_nxt;
  end

  assign lane_o = lane_q;
endmodule

// File: rtl/lvds_tx_7to1.sv
module lvds_tx_7to1
  import lvds_ser_pkg::*;
#(
  parameter int LANES     = 5,
  parameter int MIN_LANES = 3,
  parameter int STEPS     = 7,
  parameter int CLK_HIGH  = 4,
  localparam int SW = $clog2(STEPS),
  localparam int MW = mode_bits(LANES, MIN_LANES),
  localparam int WW = LANES * STEPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WW-1:0]    pix_data,
  input  logic             pix_load,
  input  logic [MW-1:0]    lane_mode,
  output logic [LANES-1:0] lane_out,
  output logic             clk_lane_out
);
  localparam logic [SW-1:0] HI_STEPS = SW'(CLK_HIGH);

  logic [SW-1:0] step_nxt;
  logic          wrap;
  logic [WW-1:0] word_nxt;
  logic [MW-1:0] mode_nxt;
  logic          clk_q;

  lvds_step_seq #(.STEPS(STEPS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .step_nxt_o (step_nxt),
    .wrap_o     (wrap)
  );

  lvds_pixel_hold #(.WW(WW), .MW(MW)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .load_i     (pix_load),
    .data_i     (pix_data),
    .mode_i     (lane_mode),
    .capture_i  (wrap),
    .word_nxt_o (word_nxt),
    .mode_nxt_o (mode_nxt)
  );

  lvds_lane_mux #(.LANES(LANES), .MIN_LANES(MIN_LANES), .STEPS(STEPS)) u_mux (
    .clk    (clk),
    .rst    (rst),
    .word_i (word_nxt),
    .mode_i (mode_nxt),
    .step_i (step_nxt),
    .lane_o (lane_out)
  );

  // The clock lane is registered alongside the data so they leave together.
  always_ff @(posedge clk) begin
    if (rst) clk_q <= 1'b0;
    else     clk_q <= (step_nxt < HI_STEPS);
  end

  assign clk_lane_out = clk_q;
endmodule

// File: rtl/lvds_tx_7to1_chk.sv
module lvds_tx_7to1_chk
  import lvds_ser_pkg::*;
#(
  parameter int LANES     = 5,
  parameter int MIN_LANES = 3,
  parameter int STEPS     = 7,
  parameter int CLK_HIGH  = 4,
  localparam int SW = $clog2(STEPS),
  localparam int MW = mode_bits(LANES, MIN_LANES)
) (
  input logic             clk,
  input logic             rst,
  input logic [MW-1:0]    lane_mode,
  input logic [LANES-1:0] lane_out,
  input logic             clk_lane_out
);
  localparam logic [SW-1:0] LAST     = SW'(STEPS - 1);
  localparam logic [SW-1:0] HI_STEPS = SW'(CLK_HIGH);

  // Independent phase count, started on the first edge after reset.
  logic          started_q;
  logic [SW-1:0] ph_q;
  logic [MW-1:0] mode_seen_q;
  logic [LANES-1:0] en_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q   <= 1'b0;
      ph_q        <= '0;
      mode_seen_q <= '0;
    end else begin
      started_q <= 1'b1;
      if (!started_q || ph_q == LAST) mode_seen_q <= lane_mode;
      if (!started_q)          ph_q <= '0;
      else if (ph_q == LAST)   ph_q <= '0;
      else                     ph_q <= ph_q + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_en
    assign en_mask[g] = lane_on(int'(mode_seen_q), g, MIN_LANES);
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (lane_out == '0 && !clk_lane_out));

  // R3
  a_r3_clk_shape: assert property (@(posedge clk) disable iff (rst)
    started_q |-> (clk_lane_out == (ph_q < HI_STEPS)));

  // R2
  a_r2_rise_at_step0: assert property (@(posedge clk) disable iff (rst)
    (started_q && $rose(clk_lane_out)) |-> (ph_q == '0));

  // R6
  a_r6_idle_lanes_low: assert property (@(posedge clk) disable iff (rst)
    started_q |-> ((lane_out & ~en_mask) == '0));
endmodule

bind lvds_tx_7to1 lvds_tx_7to1_chk #(
  .LANES(LANES), .MIN_LANES(MIN_LANES), .STEPS(STEPS), .CLK_HIGH(CLK_HIGH)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lane_mode    (lane_mode),
  .lane_out     (lane_out),
  .clk_lane_out (clk_lane_out)
);

// File: tb/lvds_tx_7to1_bench.sv
module lvds_tx_7to1_bench;
  localparam int LANES = 5;
  localparam int STEPS = 7;
  localparam int WW    = LANES * STEPS;

  typedef struct packed {
    logic [LANES-1:0] lanes;
    logic             clk;
  } frame_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WW-1:0]    pix_data = '0;
  logic             pix_load = 1'b0;
  logic [1:0]       lane_mode = 2'd0;
  logic [LANES-1:0] lane_out;
  logic             clk_lane_out;

  int total = 0;
  int fails = 0;
  bit mon_on = 1'b0;
  frame_t exp_q[$];
  logic [WW-1:0] m_word = '0;

  always #5 clk = ~clk;

  lvds_tx_7to1 u_lvds_tx_7to1 (
    .clk          (clk),
    .rst          (rst),
    .pix_data     (pix_data),
    .pix_load     (pix_load),
    .lane_mode    (lane_mode),
    .lane_out     (lane_out),
    .clk_lane_out (clk_lane_out)
  );

  // Expected seven frames for one period, built from the requirements.
  task automatic push_period(input logic [WW-1:0] w, input logic [1:0] md);
    int nl;
    nl = (md == 2'd0) ? 3 : (md == 2'd1) ? 4 : 5;
    for (int s = 0; s < STEPS; s++) begin
      frame_t f;
      f.clk = (s < 4);
      for (int i = 0; i < LANES; i++)
        f.lanes[i] = (i < nl) ? w[i*STEPS + (STEPS-1-s)] : 1'b0;
      exp_q.push_back(f);
    end
  endtask

  // Drives one period; its strobes and final mode decide the next period.
  task automatic drive_period(input logic [WW-1:0] d1, input int c1,
                              input logic [WW-1:0] d2, input int c2,
                              input logic [1:0] md, input logic [1:0] md_early);
    logic [WW-1:0] w;
    w = m_word;
    for (int c = 0; c < STEPS; c++) begin
      if (c == c2)      w = d2;
      else if (c == c1) w = d1;
    end
    m_word = w;
    push_period(w, md);
    for (int c = 0; c < STEPS; c++) begin
      @(negedge clk);
      pix_load  = (c == c1) || (c == c2);
      pix_data  = (c == c2) ? d2 : (c == c1) ? d1 : {$urandom, $urandom};
      lane_mode = (c == STEPS-1) ? md : md_early;
    end
  endtask

  // Monitor: pops one expected frame per cycle once the sequence runs.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (exp_q.size() == 0) begin
          total++; fails++;
          $display("FAIL R2 expected frame missing: lanes=%b clk=%b expected=none", lane_out, clk_lane_out);
        end else begin
          frame_t e;
          e = exp_q.pop_front();
          total++;
          if (clk_lane_out !== e.clk) begin
            fails++;
            $display("FAIL R2 R3 clock lane: actual=%b expected=%b", clk_lane_out, e.clk);
          end
          total++;
          if (lane_out !== e.lanes) begin
            fails++;
            $display("FAIL R4 R5 R6 R7 R8 R9 data lanes: actual=%b expected=%b", lane_out, e.lanes);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1: outputs low under reset even with a strobe present
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      pix_load = 1'b1;
      pix_data = {$urandom, $urandom};
      lane_mode = 2'd2;
      total++;
      if (lane_out !== '0 || clk_lane_out !== 1'b0) begin
        fails++;
        $display("FAIL R1 reset outputs: actual=%b/%b expected=00000/0", lane_out, clk_lane_out);
      end
    end
    // Release: the first period serializes the cleared word (R1).
    push_period('0, 2'd0);
    @(negedge clk);
    rst = 1'b0;
    pix_load = 1'b0;
    lane_mode = 2'd0;
    @(posedge clk);
    mon_on = 1'b1;

    // R4 R6: single strobe early, three lanes
    drive_period(35'h4_5A3C_1E96, 0, '0, -1, 2'd0, 2'd0);
    // R7 R5: no strobe, word repeats on four lanes
    drive_period('0, -1, '0, -1, 2'd1, 2'd1);
    // R7: strobe on the last cycle of the period, five lanes
    drive_period(35'h7_0F0F_F0F0, 6, '0, -1, 2'd2, 2'd2);
    // R7: two strobes, the later one wins; mode 3 gives five lanes (R5)
    drive_period(35'h1_1111_1111, 1, 35'h6_DEAD_BEEF, 4, 2'd3, 2'd3);
    // R8: early mode value differs from the boundary value
    drive_period(35'h2_AAAA_5555, 3, '0, -1, 2'd0, 2'd2);
    // R9: data wiggles without strobe
    drive_period('0, -1, '0, -1, 2'd2, 2'd2);
    // R4: all ones on four lanes
    drive_period({WW{1'b1}}, 5, '0, -1, 2'd1, 2'd0);
    // R4: alternating bits on five lanes
    drive_period(35'h5_5555_5555, 2, '0, -1, 2'd2, 2'd1);
    // R8: boundary mode 0 after five lanes
    drive_period(35'h3_C3C3_3C3C, 0, '0, -1, 2'd0, 2'd2);

    @(negedge clk);
    pix_load = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    total++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 frames left unchecked: actual=%0d expected=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule